// File: doc/BRIEF.md
# Coprocessor Register Debug Scan Chain

This block is one data register of a debug scan path. An external TAP controller supplies the test clock, serial input and the capture, shift and update strobes. Through the block, a debug host can read and write any 32-bit register of an attached coprocessor. The host shifts in a single 48-bit frame. The frame carries a data word, an access flag, a packed register address and a direction bit. On the update strobe the block turns that frame into a request on a simple request/acknowledge port.

The host then learns whether the access has finished by rescanning the chain with no-operation frames. The access-flag position of each captured frame reads 1 once the most recent access has completed. When that access was a read, the same captured frame carries the returned word in its data field, so one scan both reports completion and delivers the data.

The chain responds only while the scan-chain number presented to it equals its own number (15 by default) and the internal-test instruction is active. The TAP state machine, the instruction register and the meaning of the coprocessor registers lie outside the block.

Top module: `cpreg_scan_chain`

## Requirements
- R1: The frame is 48 bits. Bits 31:0 hold the data, bit 32 the access flag, bits 46:33 the address and bit 47 the direction. Each shift cycle moves the register one place toward bit 0. TDI enters at bit 47 and TDO always shows bit 0, so a frame leaves least significant bit first.
- R2: The 14-bit address field is presented unchanged on cp_addr. Its layout is opcode_1 in 13:11, opcode_2 in 10:8, CRn in 7:4 and CRm in 3:0.
- R3: An update with the access flag at 1 starts an access one cycle later. A direction bit of 1 gives a write of the frame's data word. A direction bit of 0 gives a read.
- R4: An update with the access flag at 0 starts nothing, whatever the direction bit and data hold.
- R5: cp_req stays high with cp_wr, cp_addr and cp_wdata stable until a cycle with cp_ack high. It falls in the following cycle.
- R6: A capture loads the access-flag position with 1 only when the most recent access has completed. While an access is outstanding it loads 0.
- R7: A capture loads the data field with the word returned by the most recent completed read, including a zero. It loads 0 after a completed write or while an access is outstanding. The address and direction positions capture 0.
- R8: An update that requests an access while another is outstanding is ignored. The outstanding request and its fields are not altered.
- R9: After reset no access is outstanding, and the first capture yields an all-zero frame.
- R10: Capture, shift and update have no effect unless chain_num equals 15 and intest_sel is high. While the chain is unselected, the shift register holds its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock from the TAP |
| rst_n | input | 1 | Synchronous active-low reset |
| chain_num | input | 4 | Currently selected scan-chain number |
| intest_sel | input | 1 | Internal-test instruction active |
| capture_en | input | 1 | Capture strobe from the TAP |
| shift_en | input | 1 | Shift strobe from the TAP |
| update_en | input | 1 | Update strobe from the TAP |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (register bit 0) |
| cp_req | output | 1 | Coprocessor access request |
| cp_wr | output | 1 | 1 = write, 0 = read |
| cp_addr | output | 14 | Packed opcode/register address |
| cp_wdata | output | 32 | Write data |
| cp_ack | input | 1 | Coprocessor acknowledge |
| cp_rdata | input | 32 | Read data, valid with cp_ack |

## Verification
A wrong access phase shows at the very next capture. A stuck outstanding state leaves the access flag at 0 in every poll. A phase that completes too early reports 1 before cp_req has dropped, and that is visible on the first poll against a long latency. A corrupted read buffer or misplaced field shows up in the shifted-out word of that same scan. Misrouted address or direction bits show on cp_addr and cp_wr one cycle after the update. A lost hold or ignore rule shows as a changed request or as a second request within the same outstanding window.

// File: rtl/cpreg_chain_pkg.sv
// Package: shared constants and the access phase type of the coprocessor
// register scan chain. Assumes a 4-bit scan-chain number space.
package cpreg_chain_pkg;
    localparam int unsigned CPC_DATA_W   = 32;
    localparam int unsigned CPC_ADDR_W   = 14;
    localparam int unsigned CPC_CHAIN_W  = 4;
    localparam int unsigned CPC_CHAIN_ID = 15;

    // Phase of the single access the chain can have in flight.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,   // nothing issued since reset
        PH_BUSY = 2'd1,   // request outstanding on the port
        PH_DONE = 2'd2    // most recent access acknowledged
    } cpc_phase_e;
endpackage

// File: rtl/cpc_chain_select.sv
// Module: qualifies the TAP strobes with the chain selection.
// Assumes chain_num and intest_sel are stable while the strobes are used.
module cpc_chain_select #(
    parameter int unsigned CHAIN_W  = 4,
    parameter int unsigned CHAIN_ID = 15
) (
    input  logic [CHAIN_W-1:0] chain_num,
    input  logic               intest_sel,
    input  logic               capture_en,
    input  logic               shift_en,
    input  logic               update_en,
    output logic               sel_capture,
    output logic               sel_shift,
    output logic               sel_update
);
    localparam logic [CHAIN_W-1:0] OWN_ID = CHAIN_W'(CHAIN_ID);

    logic chosen;

    // Gate every strobe with the chain match and the test instruction.
    always_comb begin
        chosen      = (chain_num == OWN_ID) && intest_sel;
        sel_capture = chosen && capture_en;
        sel_shift   = chosen && shift_en;
        sel_update  = chosen && update_en;
    end
endmodule

// File: rtl/cpc_scan_reg.sv
// Module: the serial frame register. Capture has priority over shift.
// TDI enters at the top bit and TDO is bit 0, so frames move LSB first.
module cpc_scan_reg #(
    parameter int unsigned FRAME_W = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cap_en,
    input  logic               sh_en,
    input  logic               tdi,
    input  logic [FRAME_W-1:0] cap_val,
    output logic [FRAME_W-1:0] frame_q,
    output logic               tdo
);
    // Load the capture value or shift one place toward bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (cap_en) begin
            frame_q <= cap_val;
        end else if (sh_en) begin
            frame_q <= {tdi, frame_q[FRAME_W-1:1]};
        end
    end

    // Serial output is the low bit of the register.
    always_comb tdo = frame_q[0];
endmodule

// File: rtl/cpc_access_ctrl.sv
// Module: turns an update into one coprocessor request, holds it until
// acknowledge, tracks completion and keeps the most recent read word.
// Assumes cp_ack is only meaningful while cp_req is high.
module cpc_access_ctrl
    import cpreg_chain_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic              f_acc,
    input  logic              f_rnw,
    input  logic [ADDR_W-1:0] f_addr,
    input  logic [DATA_W-1:0] f_data,
    output logic              done_flag,
    output logic [DATA_W-1:0] rd_word,
    output logic              cp_req,
    output logic              cp_wr,
    output logic [ADDR_W-1:0] cp_addr,
    output logic [DATA_W-1:0] cp_wdata,
    input  logic              cp_ack,
    input  logic [DATA_W-1:0] cp_rdata
);
    cpc_phase_e        phase;
    logic              cmd_wr;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic [DATA_W-1:0] rd_buf;

    // Advance the phase; a new access is accepted only when none is busy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_IDLE;
            cmd_wr   <= 1'b0;
            cmd_addr <= '0;
            cmd_data <= '0;
            rd_buf   <= '0;
        end else if (phase == PH_BUSY) begin
            if (cp_ack) begin
                phase <= PH_DONE;
                if (!cmd_wr) begin
                    rd_buf <= cp_rdata;
                end
            end
        end else if (upd_en && f_acc) begin
            phase    <= PH_BUSY;
            cmd_wr   <= f_rnw;
            cmd_addr <= f_addr;
            cmd_data <= f_data;
            rd_buf   <= '0;
        end
    end

    // Drive the port and the status seen by the next capture.
    always_comb begin
        cp_req    = (phase == PH_BUSY);
        cp_wr     = cmd_wr;
        cp_addr   = cmd_addr;
        cp_wdata  = cmd_data;
        done_flag = (phase == PH_DONE);
        rd_word   = rd_buf;
    end
endmodule

// File: rtl/cpreg_scan_chain.sv
// Module: top of the coprocessor register scan chain. Splits the frame
// into fields, builds the capture value and wires the sub-blocks.
// Assumes the TAP delivers single-cycle strobes synchronous to clk.
module cpreg_scan_chain
    import cpreg_chain_pkg::*;
#(
    parameter int unsigned DATA_W   = CPC_DATA_W,
    parameter int unsigned ADDR_W   = CPC_ADDR_W,
    parameter int unsigned CHAIN_W  = CPC_CHAIN_W,
    parameter int unsigned CHAIN_ID = CPC_CHAIN_ID
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CHAIN_W-1:0] chain_num,
    input  logic               intest_sel,
    input  logic               capture_en,
    input  logic               shift_en,
    input  logic               update_en,
    input  logic               tdi,
    output logic               tdo,
    output logic               cp_req,
    output logic               cp_wr,
    output logic [ADDR_W-1:0]  cp_addr,
    output logic [DATA_W-1:0]  cp_wdata,
    input  logic               cp_ack,
    input  logic [DATA_W-1:0]  cp_rdata
);
    localparam int unsigned ACC_POS = DATA_W;
    localparam int unsigned ADR_LO  = DATA_W + 1;
    localparam int unsigned RNW_POS = DATA_W + ADDR_W + 1;
    localparam int unsigned FRAME_W = DATA_W + ADDR_W + 2;

    logic               sel_capture;
    logic               sel_shift;
    logic               sel_update;
    logic [FRAME_W-1:0] frame_q;
    logic [FRAME_W-1:0] cap_val;
    logic               done_flag;
    logic [DATA_W-1:0]  rd_word;

    cpc_chain_select #(
        .CHAIN_W  (CHAIN_W),
        .CHAIN_ID (CHAIN_ID)
    ) u_sel (
        .chain_num   (chain_num),
        .intest_sel  (intest_sel),
        .capture_en  (capture_en),
        .shift_en    (shift_en),
        .update_en   (update_en),
        .sel_capture (sel_capture),
        .sel_shift   (sel_shift),
        .sel_update  (sel_update)
    );

    // Capture value: direction and address read back as zero.
    always_comb cap_val = {1'b0, {ADDR_W{1'b0}}, done_flag, rd_word};

    cpc_scan_reg #(
        .FRAME_W (FRAME_W)
    ) u_sreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (sel_capture),
        .sh_en   (sel_shift),
        .tdi     (tdi),
        .cap_val (cap_val),
        .frame_q (frame_q),
        .tdo     (tdo)
    );

    cpc_access_ctrl #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W)
    ) u_acc (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_en    (sel_update),
        .f_acc     (frame_q[ACC_POS]),
        .f_rnw     (frame_q[RNW_POS]),
        .f_addr    (frame_q[ADR_LO +: ADDR_W]),
        .f_data    (frame_q[DATA_W-1:0]),
        .done_flag (done_flag),
        .rd_word   (rd_word),
        .cp_req    (cp_req),
        .cp_wr     (cp_wr),
        .cp_addr   (cp_addr),
        .cp_wdata  (cp_wdata),
        .cp_ack    (cp_ack),
        .cp_rdata  (cp_rdata)
    );
endmodule

// File: rtl/cpreg_scan_chain_chk.sv
// Module: protocol checker for the scan chain, bound to the top module.
module cpreg_scan_chain_chk #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 14
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     sel_capture,
    input logic                     sel_shift,
    input logic                     sel_update,
    input logic [DATA_W+ADDR_W+1:0] frame_q,
    input logic                     tdo,
    input logic                     cp_req,
    input logic                     cp_ack,
    input logic                     cp_wr,
    input logic [ADDR_W-1:0]        cp_addr,
    input logic [DATA_W-1:0]        cp_wdata
);
    localparam int unsigned ACC_POS = DATA_W;
    localparam int unsigned ADR_LO  = DATA_W + 1;
    localparam int unsigned RNW_POS = DATA_W + ADDR_W + 1;

    p_shift_lsb_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sel_shift && !sel_capture |=> tdo == $past(frame_q[1]));

    p_start_fields_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !cp_req && sel_update && frame_q[ACC_POS] |=>
            cp_req && cp_wr == $past(frame_q[RNW_POS])
            && cp_addr == $past(frame_q[ADR_LO +: ADDR_W])
            && cp_wdata == $past(frame_q[DATA_W-1:0]));

    p_nop_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !cp_req && sel_update && !frame_q[ACC_POS] |=> !cp_req);

    p_req_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cp_req && !cp_ack |=> cp_req && $stable(cp_wr) && $stable(cp_addr)
            && $stable(cp_wdata));

    p_req_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cp_req && cp_ack |=> !cp_req);

    p_busy_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cp_req && sel_capture |=> !frame_q[ACC_POS]);

    p_reset_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !cp_req);
endmodule

bind cpreg_scan_chain cpreg_scan_chain_chk #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sel_capture (sel_capture),
    .sel_shift   (sel_shift),
    .sel_update  (sel_update),
    .frame_q     (frame_q),
    .tdo         (tdo),
    .cp_req      (cp_req),
    .cp_ack      (cp_ack),
    .cp_wr       (cp_wr),
    .cp_addr     (cp_addr),
    .cp_wdata    (cp_wdata)
);

// File: tb/tb_cpreg_scan_chain.sv
// Bench: drives the TAP strobes, models a register bank with adjustable
// latency and checks the scanned-out frames against computed values.
module tb_cpreg_scan_chain;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  chain_num = 4'd15;
    logic        intest_sel = 1'b1;
    logic        capture_en = 1'b0;
    logic        shift_en = 1'b0;
    logic        update_en = 1'b0;
    logic        tdi = 1'b0;
    logic        tdo;
    logic        cp_req;
    logic        cp_wr;
    logic [13:0] cp_addr;
    logic [31:0] cp_wdata;
    logic        cp_ack;
    logic [31:0] cp_rdata;

    int checks = 0;
    int failures = 0;
    int lat = 3;

    always #5 clk = ~clk;

    cpreg_scan_chain dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .chain_num  (chain_num),
        .intest_sel (intest_sel),
        .capture_en (capture_en),
        .shift_en   (shift_en),
        .update_en  (update_en),
        .tdi        (tdi),
        .tdo        (tdo),
        .cp_req     (cp_req),
        .cp_wr      (cp_wr),
        .cp_addr    (cp_addr),
        .cp_wdata   (cp_wdata),
        .cp_ack     (cp_ack),
        .cp_rdata   (cp_rdata)
    );

    // Register bank: addresses with upper six bits zero plus 14'h3FFF.
    logic [31:0] bank [256];
    logic [31:0] top_reg;
    int          cnt;
    always @(posedge clk) begin
        if (!rst_n) begin
            cp_ack <= 1'b0; cp_rdata <= '0; cnt <= 0; top_reg <= '0;
            for (int i = 0; i < 256; i++) bank[i] <= '0;
        end else if (cp_ack) begin
            cp_ack <= 1'b0; cnt <= 0;
        end else if (cp_req) begin
            if (cnt == lat) begin
                cp_ack <= 1'b1;
                if (cp_wr) begin
                    if (cp_addr[13:8] == 6'd0) bank[cp_addr[7:0]] <= cp_wdata;
                    else if (cp_addr == 14'h3FFF) top_reg <= cp_wdata;
                end else begin
                    if (cp_addr[13:8] == 6'd0) cp_rdata <= bank[cp_addr[7:0]];
                    else if (cp_addr == 14'h3FFF) cp_rdata <= top_reg;
                    else cp_rdata <= '0;
                end
            end else begin
                cnt <= cnt + 1;
            end
        end
    end

    // Request monitor: count starts, record fields, measure high time.
    logic        prev_req;
    int          rise_cnt, run, last_run;
    logic [13:0] rec_addr;
    logic        rec_wr;
    logic [31:0] rec_wdata;
    always @(posedge clk) begin
        if (!rst_n) begin
            prev_req <= 1'b0; rise_cnt <= 0; run <= 0; last_run <= 0;
            rec_addr <= '0; rec_wr <= 1'b0; rec_wdata <= '0;
        end else begin
            prev_req <= cp_req;
            if (cp_req && !prev_req) begin
                rise_cnt <= rise_cnt + 1;
                rec_addr <= cp_addr; rec_wr <= cp_wr; rec_wdata <= cp_wdata;
            end
            if (cp_req) run <= run + 1;
            else if (prev_req) begin last_run <= run; run <= 0; end
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [47:0] mk(input logic rnw, input logic [2:0] op1,
        input logic [2:0] op2, input logic [3:0] crn, input logic [3:0] crm,
        input logic acc, input logic [31:0] d);
        return {rnw, op1, op2, crn, crm, acc, d};
    endfunction

    // Full scan: capture, 48 shifts, update. Called and returns at negedge.
    task automatic scan(input logic [47:0] fin, output logic [47:0] fout);
        capture_en = 1'b1; @(negedge clk); capture_en = 1'b0;
        for (int i = 0; i < 48; i++) begin
            shift_en = 1'b1; tdi = fin[i]; fout[i] = tdo; @(negedge clk);
        end
        shift_en = 1'b0; update_en = 1'b1; @(negedge clk); update_en = 1'b0;
    endtask

    // Shift only, no capture or update.
    task automatic shift_only(input logic [47:0] fin, output logic [47:0] fout);
        for (int i = 0; i < 48; i++) begin
            shift_en = 1'b1; tdi = fin[i]; fout[i] = tdo; @(negedge clk);
        end
        shift_en = 1'b0;
    endtask

    // Rescan with NOP frames until the access flag reads 1.
    task automatic poll(output logic [47:0] fout, output int n, output logic first_flag);
        n = 0; first_flag = 1'b0;
        do begin
            scan(48'h0, fout);
            if (n == 0) first_flag = fout[32];
            n++;
        end while (!fout[32] && n < 40);
    endtask

    // Write then read back a register; returns the polled read frame.
    task automatic wr_rd(input logic [2:0] o1, input logic [2:0] o2, input logic [3:0] rn,
        input logic [3:0] rm, input logic [31:0] v, output logic [47:0] rf);
        logic [47:0] f; int n; logic ff;
        scan(mk(1'b1, o1, o2, rn, rm, 1'b1, v), f);
        poll(f, n, ff);
        scan(mk(1'b0, o1, o2, rn, rm, 1'b1, 32'h0), f);
        poll(rf, n, ff);
    endtask

    logic        finished = 1'b0;
    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [47:0] f, g;
        int n, base;
        logic ff;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: first capture after reset is all zero, nothing requested.
        scan(48'h0, f);
        check("R9 reset frame", {16'h0, f}, 64'h0);
        check("R9 no request", rise_cnt, 0);

        // R1: a frame shifted in comes out unchanged, LSB first.
        shift_only(48'hA5C3_0F1E_7D29, f);
        shift_only(48'h0, g);
        check("R1 shift through", {16'h0, g}, {16'h0, 48'hA5C3_0F1E_7D29});
        check("R4 no update no access", rise_cnt, 0);

        // R2/R3/R5/R7: write with short latency, then poll.
        lat = 3;
        scan(mk(1'b1, 3'd0, 3'd0, 4'd1, 4'd2, 1'b1, 32'hDEAD_BEEF), f);
        poll(f, n, ff);
        check("R2 packed address", rec_addr, 14'h012);
        check("R3 write direction", rec_wr, 1'b1);
        check("R3 write data", rec_wdata, 32'hDEAD_BEEF);
        check("R6 done after write", f[32], 1'b1);
        check("R7 write completion data zero", {16'h0, f[47:33], f[31:0]}, 64'h0);
        check("R5 request high cycles", last_run, lat + 2);

        // R3/R7: back-to-back read of the same register.
        scan(mk(1'b0, 3'd0, 3'd0, 4'd1, 4'd2, 1'b1, 32'h0), f);
        poll(f, n, ff);
        check("R3 read direction", rec_wr, 1'b0);
        check("R7 read data", f[31:0], 32'hDEAD_BEEF);
        check("R7 upper fields zero", f[47:33], 15'h0);

        // R2: every subfield at its maximum.
        wr_rd(3'd7, 3'd7, 4'd15, 4'd15, 32'h1357_9BDF, f);
        check("R2 max address", rec_addr, 14'h3FFF);
        check("R7 max address read", f[31:0], 32'h1357_9BDF);

        // R4: access flag 0 starts nothing, even with direction 1.
        base = rise_cnt;
        scan(mk(1'b1, 3'd0, 3'd0, 4'd1, 4'd2, 1'b0, 32'h0BAD_0BAD), f);
        scan(48'h0, f);
        repeat (10) @(negedge clk);
        check("R4 no start", rise_cnt, base);
        check("R4 flag still shows last done", f[32], 1'b1);
        scan(mk(1'b0, 3'd0, 3'd0, 4'd1, 4'd2, 1'b1, 32'h0), f);
        poll(f, n, ff);
        check("R4 register untouched", f[31:0], 32'hDEAD_BEEF);

        // R6/R5: long latency, several NOP polls.
        lat = 150;
        scan(mk(1'b0, 3'd0, 3'd0, 4'd1, 4'd2, 1'b1, 32'h0), f);
        poll(f, n, ff);
        check("R6 first poll busy", ff, 1'b0);
        check("R6 several polls", n >= 4, 1'b1);
        check("R6 final done", f[32], 1'b1);
        check("R7 long read data", f[31:0], 32'hDEAD_BEEF);
        check("R5 long request high cycles", last_run, lat + 2);

        // R8: second access while busy is ignored.
        base = rise_cnt;
        scan(mk(1'b1, 3'd0, 3'd0, 4'd3, 4'd4, 1'b1, 32'h1111_2222), f);
        scan(mk(1'b1, 3'd0, 3'd0, 4'd3, 4'd4, 1'b1, 32'h9999_8888), f);
        check("R6 busy capture flag", f[32], 1'b0);
        check("R7 busy capture data", f[31:0], 32'h0);
        poll(f, n, ff);
        check("R8 single request", rise_cnt, base + 1);
        check("R8 first data kept", rec_wdata, 32'h1111_2222);
        lat = 2;
        scan(mk(1'b0, 3'd0, 3'd0, 4'd3, 4'd4, 1'b1, 32'h0), f);
        poll(f, n, ff);
        check("R8 stored value", f[31:0], 32'h1111_2222);

        // R7: unimplemented register reads back as zero.
        wr_rd(3'd3, 3'd2, 4'd2, 4'd2, 32'hFFFF_FFFF, f);
        check("R7 zero read done", f[32], 1'b1);
        check("R7 zero read data", f[31:0], 32'h0);

        // R10: unselected shift holds; unselected updates start nothing.
        scan(mk(1'b0, 3'd0, 3'd0, 4'd1, 4'd2, 1'b1, 32'h0), f);
        poll(f, n, ff);
        capture_en = 1'b1; @(negedge clk); capture_en = 1'b0;
        chain_num = 4'd3;
        shift_only(48'hFFFF_FFFF_FFFF, g);
        chain_num = 4'd15;
        shift_only(48'h0, g);
        check("R10 hold while unselected", {16'h0, g},
              {16'h0, 1'b0, 14'h0, 1'b1, 32'hDEAD_BEEF});
        base = rise_cnt;
        chain_num = 4'd14;
        scan(mk(1'b1, 3'd0, 3'd0, 4'd1, 4'd2, 1'b1, 32'h5555_5555), f);
        chain_num = 4'd15; intest_sel = 1'b0;
        scan(mk(1'b1, 3'd0, 3'd0, 4'd1, 4'd2, 1'b1, 32'h6666_6666), f);
        intest_sel = 1'b1;
        repeat (10) @(negedge clk);
        check("R10 no access unselected", rise_cnt, base);
        scan(mk(1'b0, 3'd0, 3'd0, 4'd1, 4'd2, 1'b1, 32'h0), f);
        poll(f, n, ff);
        check("R10 register unchanged", f[31:0], 32'hDEAD_BEEF);

        // Sweep: one register per CRn/CRm pair on a diagonal, varied latency.
        for (int k = 0; k < 16; k++) begin
            logic [31:0] v;
            v = 32'h9E37_79B9 * (k + 1);
            lat = k % 5;
            wr_rd(3'd0, 3'd0, 4'(k), 4'(15 - k), v, f);
            check("R3 sweep readback", f[31:0], v);
            check("R2 sweep address", rec_addr, {6'd0, 4'(k), 4'(15 - k)});
        end

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule